// File: doc/BRIEF.md
# Fault versus Trojan recovery controller

This controller sits beside a duplicated datapath whose comparator reports a one-bit mismatch each cycle. It decides from the timing of the mismatches what kind of event has happened. A mismatch that clears after a one-cycle rollback to the history registers is a transient fault. A mismatch that returns during the rollback is a configuration fault, and the controller asks for a reconfiguration. A mismatch that is still there after reconfiguration is a Trojan. The sequence present, absent, present on three back-to-back cycles is also a Trojan. A Trojan puts the block into a latched fail-safe state, which stops the outputs and raises an alarm. This state also stops the design from reconfiguring without end.

Reconfiguration lasts a fixed number of cycles, counted by an internal timer. Three saturating counters record transient faults, configuration faults and completed reconfigurations. A rate monitor marks the event stream as suspicious when too many rollback steps fall inside one observation window.

Top module: `fault_trojan_ctrl`

## Requirements
- R1: After reset, out_en_o is 1, and alarm_o, rollback_sel_o, reconf_req_o and suspect_o are 0, and all three counters are 0.
- R2: A mismatch seen in normal operation drives rollback_sel_o high in the next cycle, for exactly one cycle. out_en_o stays high during that cycle.
- R3: If mismatch_i is 0 during the rollback cycle, the transient counter increments by one and normal operation resumes in the next cycle.
- R4: If mismatch_i is 1 during the rollback cycle, the configuration-fault counter increments by one. reconf_req_o is then high for RECONF_CYCLES consecutive cycles, with out_en_o low, and the reconfiguration counter increments when that interval ends.
- R5: Reconfiguration is followed by one verification cycle in which out_en_o is low. If mismatch_i is 0 in that cycle, normal operation (out_en_o = 1) resumes in the next cycle.
- R6: A mismatch during the verification cycle sets alarm_o to 1 and out_en_o to 0 from the next cycle on. The block stays in that state, ignoring mismatch_i, until reset.
- R7: In normal operation, a mismatch in the first cycle after a clean rollback (the pattern 1, 0, 1 on three consecutive cycles) enters the same alarm state as R6, with no reconfiguration.
- R8: Each counter is CNT_W bits wide and holds at 2^CNT_W − 1 instead of wrapping.
- R9: Every rollback cycle is one recovery event. A window counter spans WINDOW cycles and clears the event count when it wraps; the count restarts at 0 in the cycle after the wrap cycle. When an event brings the count within the current window to EVENT_LIMIT, suspect_o rises in the next cycle and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mismatch_i | input | 1 | Per-cycle comparison failure from the duplicated datapath |
| rollback_sel_o | output | 1 | Select history registers this cycle |
| reconf_req_o | output | 1 | Reconfiguration in progress |
| out_en_o | output | 1 | Primary outputs may be used |
| alarm_o | output | 1 | Trojan detected, fail-safe latched |
| suspect_o | output | 1 | Recovery-event rate exceeded in a window |
| cnt_transient_o | output | CNT_W | Transient fault count |
| cnt_config_o | output | CNT_W | Configuration fault count |
| cnt_reconf_o | output | CNT_W | Completed reconfiguration count |

## Verification
The hardest situation to reach is a mismatch in the single verification cycle. It needs a mismatch, then a second mismatch during rollback, then a mismatch that lands exactly RECONF_CYCLES + 2 cycles after the first. The bench uses a short reconfiguration time and sweeps every 8-cycle mismatch pattern, starting from reset each time, so this timing and the 1, 0, 1 pattern are both certain to occur. A reference model in the bench predicts every output in every cycle. Long runs of sparse mismatches then drive the counters into saturation and cross several window boundaries.

// File: rtl/fault_trojan_ctrl.sv
module fault_trojan_ctrl #(
  parameter int RECONF_CYCLES = 16,
  parameter int WINDOW        = 1024,
  parameter int EVENT_LIMIT   = 4,
  parameter int CNT_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mismatch_i,
  output logic             rollback_sel_o,
  output logic             reconf_req_o,
  output logic             out_en_o,
  output logic             alarm_o,
  output logic             suspect_o,
  output logic [CNT_W-1:0] cnt_transient_o,
  output logic [CNT_W-1:0] cnt_config_o,
  output logic [CNT_W-1:0] cnt_reconf_o
);
  localparam int TW = $clog2(RECONF_CYCLES + 1);
  localparam int WW = $clog2(WINDOW + 1);
  localparam int EW = $clog2(EVENT_LIMIT + 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  typedef enum logic [2:0] {S_RUN, S_ROLL, S_RECONF, S_VERIFY, S_TROJAN} st_t;
  st_t st;

  logic [TW-1:0] tmr;
  logic [WW-1:0] win;
  logic [EW-1:0] evc;
  logic          just_clean;

  wire tmr_last = (tmr == TW'(RECONF_CYCLES - 1));
  wire win_wrap = (win == WW'(WINDOW - 1));
  wire event_hit = (st == S_ROLL);
  wire [EW-1:0] ev_base = win_wrap ? '0 : evc;
  wire limit_hit = event_hit && (ev_base == EW'(EVENT_LIMIT - 1));

  assign rollback_sel_o = (st == S_ROLL);
  assign reconf_req_o   = (st == S_RECONF);
  assign out_en_o       = (st == S_RUN) || (st == S_ROLL);
  assign alarm_o        = (st == S_TROJAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RUN;
      tmr        <= '0;
      just_clean <= 1'b0;
    end else begin
      just_clean <= (st == S_ROLL) && !mismatch_i;
      case (st)
        S_RUN:    if (mismatch_i) st <= just_clean ? S_TROJAN : S_ROLL;
        S_ROLL: begin
          tmr <= '0;
          st  <= mismatch_i ? S_RECONF : S_RUN;
        end
        S_RECONF: begin
          if (tmr_last) st <= S_VERIFY;
          else          tmr <= tmr + 1'b1;
        end
        S_VERIFY: st <= mismatch_i ? S_TROJAN : S_RUN;
        default:  st <= S_TROJAN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_transient_o <= '0;
      cnt_config_o    <= '0;
      cnt_reconf_o    <= '0;
    end else begin
      if (st == S_ROLL && !mismatch_i && cnt_transient_o != CMAX)
        cnt_transient_o <= cnt_transient_o + 1'b1;
      if (st == S_ROLL && mismatch_i && cnt_config_o != CMAX)
        cnt_config_o <= cnt_config_o + 1'b1;
      if (st == S_RECONF && tmr_last && cnt_reconf_o != CMAX)
        cnt_reconf_o <= cnt_reconf_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win       <= '0;
      evc       <= '0;
      suspect_o <= 1'b0;
    end else begin
      win <= win_wrap ? '0 : win + 1'b1;
      if (event_hit && ev_base != EW'(EVENT_LIMIT)) evc <= ev_base + 1'b1;
      else                                          evc <= ev_base;
      if (limit_hit) suspect_o <= 1'b1;
    end
  end

  a_r2_rollback_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_sel_o |=> !rollback_sel_o);
  a_r4_reconf_after_rollback: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reconf_req_o) |-> $past(rollback_sel_o));
  a_r4_outputs_held: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_req_o |-> !out_en_o);
  a_r6_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |=> alarm_o);
  a_r6_failsafe: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> (!out_en_o && !reconf_req_o && !rollback_sel_o));
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_transient_o >= $past(cnt_transient_o)) && (cnt_reconf_o >= $past(cnt_reconf_o)));
  a_r9_suspect_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    suspect_o |=> suspect_o);
endmodule

// File: tb/fault_trojan_ctrl_tb.sv
module fault_trojan_ctrl_tb;
  localparam int RC = 3, WIN = 16, LIM = 3, CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, mm = 0;
  logic rb, rq, oe, al, su;
  logic [CW-1:0] ct, cc, cr;
  int total = 0, bad = 0;
  bit done = 0;

  int m_st, m_tmr, m_recent, m_ct, m_cc, m_cr, m_win, m_evc, m_su;

  always #4 clk = ~clk;

  fault_trojan_ctrl #(.RECONF_CYCLES(RC), .WINDOW(WIN), .EVENT_LIMIT(LIM), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mismatch_i(mm), .rollback_sel_o(rb), .reconf_req_o(rq),
    .out_en_o(oe), .alarm_o(al), .suspect_o(su),
    .cnt_transient_o(ct), .cnt_config_o(cc), .cnt_reconf_o(cr));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_tmr = 0; m_recent = 0; m_ct = 0; m_cc = 0; m_cr = 0;
    m_win = 0; m_evc = 0; m_su = 0;
  endtask

  task automatic compare();
    chk("R2 rollback_sel", rb, m_st == 1);
    chk("R4 reconf_req", rq, m_st == 2);
    chk("R5 out_en", oe, (m_st == 0) || (m_st == 1));
    chk("R6 alarm", al, m_st == 4);
    chk("R3 transient count", ct, m_ct);
    chk("R4 config count", cc, m_cc);
    chk("R4 reconf count", cr, m_cr);
    chk("R9 suspect", su, m_su);
  endtask

  task automatic model_step(int m);
    int base, ev, nrec;
    ev = (m_st == 1);
    base = (m_win == WIN - 1) ? 0 : m_evc;
    nrec = (m_st == 1) && !m;
    case (m_st)
      0: if (m) m_st = m_recent ? 4 : 1;
      1: begin
        m_tmr = 0;
        if (m) begin m_st = 2; if (m_cc < CMAX) m_cc++; end
        else begin m_st = 0; if (m_ct < CMAX) m_ct++; end
      end
      2: if (m_tmr == RC - 1) begin m_st = 3; if (m_cr < CMAX) m_cr++; end
         else m_tmr++;
      3: m_st = m ? 4 : 0;
      default: m_st = 4;
    endcase
    m_recent = nrec;
    if (ev && base == LIM - 1) m_su = 1;
    m_evc = (ev && base != LIM) ? base + 1 : base;
    m_win = (m_win == WIN - 1) ? 0 : m_win + 1;
  endtask

  task automatic step(int m);
    mm = m[0];
    @(posedge clk);
    model_step(m);
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; mm = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    model_step(0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 out_en in reset", oe, 1);
    rst_n = 1;
    @(negedge clk);
    model_step(0);
    chk("R1 alarm", al, 0); chk("R1 rollback", rb, 0); chk("R1 reconf", rq, 0);
    chk("R1 suspect", su, 0); chk("R1 counters", ct + cc + cr, 0);

    for (int p = 0; p < 256; p++) begin
      do_reset();
      for (int b = 0; b < 8; b++) step((p >> b) & 1);
      for (int k = 0; k < RC + 3; k++) step(0);
    end

    do_reset();
    step(1); step(0); step(1);
    step(0);
    chk("R7 pattern 1,0,1 alarm", al, 1);
    chk("R7 no reconfiguration", cr, 0);
    for (int k = 0; k < 20; k++) step(k & 1);
    chk("R6 alarm sticky", al, 1);
    chk("R6 output held off", oe, 0);

    do_reset();
    for (int k = 0; k < 12; k++) begin
      step(1);
      for (int j = 0; j < 6; j++) step(0);
    end
    chk("R8 transient saturates", ct, CMAX);
    chk("R9 suspect after dense events", su, 1);

    do_reset();
    for (int k = 0; k < 10; k++) begin
      step(1); step(1);
      for (int j = 0; j < RC + 1; j++) step(0);
      for (int j = 0; j < 3; j++) step(0);
    end
    chk("R8 config saturates", cc, CMAX);
    chk("R8 reconf saturates", cr, CMAX);
    chk("R5 normal after clean verify", oe, 1);

    do_reset();
    for (int k = 0; k < 6; k++) begin
      step(1);
      for (int j = 0; j < WIN - 1; j++) step(0);
    end
    chk("R9 sparse events not suspect", su, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule